// File: doc/BRIEF.md
# Watchdog Clock Select and Run Control

This block is the front end of a watchdog timer. It picks one of four clock-tick sources and divides the chosen tick stream down to a slow count rate. It then advances a watchdog counter at that rate and raises a one-cycle timeout pulse when the counter overflows. Software reaches it through a small 16-bit register bus with two registers. One register selects the source, the divider and whether counting continues under a debug halt. The other holds a 4-bit run key and a write-only counter-clear strobe. A write-protect input blocks every write while it is high.

All activity stays in the system clock domain. Each source arrives as a single-cycle tick enable, and the divider produces a single-cycle enable in the same domain, so the block needs no generated clocks. Three parameters set the scale: the base divider exponent, the fixed exponent of the low-speed source and the counter width. At the default values the divided rate is close to 256 Hz and the timeout period is about 4 s.

Top module: `wdog_tick_ctrl`

## Requirements
- R1: After reset the configuration register (address 0) reads 0x0000, the control register (address 1) reads 0x000A, `wd_count` is 0 and `wd_timeout` is 0.
- R2: Configuration register layout: source select in bits 1:0, divider select in bits 5:4, debug-run in bit 8, and every other bit reads 0. Control register layout: run key in bits 3:0, clear strobe in bit 4, and bits 15:4 always read 0.
- R3: While `wr_prot` is 1, writes to either register have no effect. The stored fields do not change and no counter clear happens.
- R4: For source codes 0 and 2, divider codes 0, 1, 2 and 3 give one counter step per 2^(BASE_LOG2+3), 2^(BASE_LOG2+2), 2^(BASE_LOG2+1) and 2^BASE_LOG2 ticks of the selected source.
- R5: For source code 1 the division is always 2^LOW_LOG2, whatever the divider field holds.
- R6: For source code 3 the division is 1, so every tick advances the counter, whatever the divider field holds.
- R7: Only ticks on `src_tick[n]`, where n is the selected source code, reach the divider. Ticks on the other three inputs have no effect.
- R8: While debug-run is 0 and `dbg_halt` is 1, the counter does not advance. While debug-run is 1, it advances during a debug halt too.
- R9: A run key of 0xA stops the counter. Every other key value (0x0 to 0xF apart from 0xA) lets it advance by one on each divided step.
- R10: Writing the control register with bit 4 set clears `wd_count` to 0 one cycle after the write. Writing bit 4 as 0 leaves the count unchanged.
- R11: A step taken while the count is at its maximum (2^CNT_W - 1) wraps the count to 0 and raises `wd_timeout` for exactly one cycle.
- R12: Any change to the source or divider field restarts the divider from zero, so the first step after the change takes a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 configuration, 1 control |
| bus_wdata | input | 16 | Write data |
| wr_prot | input | 1 | Write protection, 1 blocks writes |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| src_tick | input | 4 | Single-cycle tick enables of the four sources, indexed by source code |
| dbg_halt | input | 1 | Debug halt indication |
| wd_count | output | CNT_W | Current watchdog count |
| wd_timeout | output | 1 | One-cycle pulse on counter overflow |

## Verification
The bench uses a small configuration: base exponent 1, low-speed exponent 3, 4-bit counter. It sweeps all sixteen source and divider combinations. For each one it gives one tick fewer than the expected ratio and checks that the count has not moved, then gives the last tick and checks for a single step. This catches an off-by-one ratio or a divider field that leaks into the fixed-ratio sources. Ticks on the sources that are not selected show whether the source select works. Every run key value is tried, which shows whether the stop value is decoded exactly. A divider change in mid-period shows whether the divider restarts or carries its old partial count. Protected writes, the clear strobe written as 0 and 1, debug halt with debug-run both off and on, and the overflow cycle cover the remaining paths.

// File: rtl/wdog_pkg.sv
// Shared types and constants for the watchdog clock front end.
// Assumes a 16-bit register bus with two word registers.
package wdog_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_LOW  = 2'd1,
        SRC_HIGH = 2'd2,
        SRC_EXT  = 2'd3
    } wd_src_e;

    typedef struct packed {
        logic       dbg_run;
        logic [1:0] div_sel;
        wd_src_e    src_sel;
    } wd_cfg_t;

    localparam logic [3:0] RUN_HALT_KEY = 4'hA;
    localparam logic       ADDR_CFG     = 1'b0;
    localparam logic       ADDR_CTL     = 1'b1;
    localparam int         CTL_CLR_BIT  = 4;

endpackage

// File: rtl/wdog_regs.sv
// Register file: configuration (source, divider, debug-run) and control
// (run key, clear strobe). Writes are blocked while wr_prot is high.
// Assumes single-cycle write strobes; reads are combinational.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        wr_prot,
    output logic [15:0] bus_rdata,
    output wd_cfg_t     cfg,
    output logic [3:0]  run_key,
    output logic        clr_stb
);

    logic wr_ok;
    logic unused_wdata;

    assign wr_ok        = bus_wr && !wr_prot;
    assign unused_wdata = ^{bus_wdata[15:9], bus_wdata[7:6]};

    // Register update: configuration, run key and the one-cycle clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            run_key <= RUN_HALT_KEY;
            clr_stb <= 1'b0;
        end else begin
            clr_stb <= 1'b0;
            if (wr_ok && bus_addr == ADDR_CFG) begin
                cfg.src_sel <= wd_src_e'(bus_wdata[1:0]);
                cfg.div_sel <= bus_wdata[5:4];
                cfg.dbg_run <= bus_wdata[8];
            end
            if (wr_ok && bus_addr == ADDR_CTL) begin
                run_key <= bus_wdata[3:0];
                clr_stb <= bus_wdata[CTL_CLR_BIT];
            end
        end
    end

    // Read mux: unused bits and the clear strobe read as zero.
    always_comb begin
        if (bus_addr == ADDR_CFG) begin
            bus_rdata = {7'b0, cfg.dbg_run, 2'b0, cfg.div_sel, 2'b0, cfg.src_sel};
        end else begin
            bus_rdata = {12'b0, run_key};
        end
    end

    assert_prot_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_prot) |=> ($stable(cfg) && $stable(run_key) && !clr_stb));

    assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_prot && bus_addr == ADDR_CTL) |=> (run_key == $past(bus_wdata[3:0])));

endmodule

// File: rtl/wdog_prescaler.sv
// Source select and divider. Picks the tick input named by the source code
// and emits one single-cycle enable per 2^k selected ticks. The exponent k
// depends on the source and, for sources 0 and 2, on the divider field.
// Assumes LOW_LOG2 and BASE_LOG2+3 both fit the prescaler width.
module wdog_prescaler #(
    parameter int BASE_LOG2 = 11,
    parameter int LOW_LOG2  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src_tick,
    input  logic [1:0] src_sel,
    input  logic [1:0] div_sel,
    output logic       div_tick
);

    localparam int HI_LOG2 = BASE_LOG2 + 3;
    localparam int PW      = ((HI_LOG2 > LOW_LOG2) ? HI_LOG2 : LOW_LOG2) + 1;
    localparam int SW      = $clog2(PW + 1);

    logic [3:0]    src_hit;
    logic          sel_tick;
    logic [SW-1:0] shift_amt;
    logic [PW-1:0] lim;
    logic [PW-1:0] pcnt;
    logic [3:0]    prev_sel;
    logic          restart;

    // One-hot match of each tick input against the selected source code.
    for (genvar s = 0; s < 4; s++) begin : g_src
        assign src_hit[s] = src_tick[s] && (src_sel == 2'(s));
    end
    assign sel_tick = |src_hit;

    // Division exponent from the source and divider fields.
    always_comb begin
        case (src_sel)
            2'd1:    shift_amt = SW'(LOW_LOG2);
            2'd3:    shift_amt = '0;
            default: shift_amt = SW'(HI_LOG2) - SW'(div_sel);
        endcase
        lim = (PW'(1) << shift_amt) - PW'(1);
    end

    assign restart = ({src_sel, div_sel} != prev_sel);

    // Divider count; it restarts on a configuration change and fires on the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt     <= '0;
            div_tick <= 1'b0;
            prev_sel <= '0;
        end else begin
            prev_sel <= {src_sel, div_sel};
            div_tick <= 1'b0;
            if (restart) begin
                pcnt <= '0;
            end else if (sel_tick) begin
                if (pcnt >= lim) begin
                    pcnt     <= '0;
                    div_tick <= 1'b1;
                end else begin
                    pcnt <= pcnt + PW'(1);
                end
            end
        end
    end

    assert_restart_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pcnt == '0 && !div_tick));

    assert_tick_from_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> $past(sel_tick));

endmodule

// File: rtl/wdog_counter.sv
// Watchdog counter. Steps on the divided enable when the run key allows it
// and the debug gate is open. Clears on the strobe and wraps with a
// one-cycle timeout pulse. Assumes div_tick is a single-cycle enable.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_tick,
    input  logic [3:0]       run_key,
    input  logic             clr_stb,
    input  logic             dbg_halt,
    input  logic             dbg_run,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic running;
    logic gate_open;
    logic cnt_en;

    assign running   = (run_key != RUN_HALT_KEY);
    assign gate_open = dbg_run || !dbg_halt;
    assign cnt_en    = div_tick && running && gate_open;

    // Count update: clear first, then step with wrap and timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (clr_stb) begin
                cnt <= '0;
            end else if (cnt_en) begin
                if (cnt == CNT_MAX) begin
                    cnt     <= '0;
                    timeout <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assert_dbg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !dbg_run && !clr_stb) |=> $stable(cnt));

    assert_key_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_key == RUN_HALT_KEY && !clr_stb) |=> $stable(cnt));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (cnt == '0));

    assert_wrap_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (cnt == '0));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

endmodule

// File: rtl/wdog_tick_ctrl.sv
// Top of the watchdog clock front end: register file, source select and
// divider, and the run-controlled watchdog counter.
// Assumes all source ticks are synchronous single-cycle enables on clk.
module wdog_tick_ctrl
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int LOW_LOG2  = 7,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [15:0]      bus_wdata,
    input  logic             wr_prot,
    output logic [15:0]      bus_rdata,
    input  logic [3:0]       src_tick,
    input  logic             dbg_halt,
    output logic [CNT_W-1:0] wd_count,
    output logic             wd_timeout
);

    wd_cfg_t    cfg;
    logic [3:0] run_key;
    logic       clr_stb;
    logic       div_tick;

    wdog_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_prot   (wr_prot),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .run_key   (run_key),
        .clr_stb   (clr_stb)
    );

    wdog_prescaler #(
        .BASE_LOG2 (BASE_LOG2),
        .LOW_LOG2  (LOW_LOG2)
    ) i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .src_sel  (cfg.src_sel),
        .div_sel  (cfg.div_sel),
        .div_tick (div_tick)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_tick (div_tick),
        .run_key  (run_key),
        .clr_stb  (clr_stb),
        .dbg_halt (dbg_halt),
        .dbg_run  (cfg.dbg_run),
        .cnt      (wd_count),
        .timeout  (wd_timeout)
    );

endmodule

// File: tb/test_wdog_tick_ctrl.sv
module test_wdog_tick_ctrl;

    localparam int BL = 1;
    localparam int LL = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_addr = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic          wr_prot = 1'b0;
    logic [15:0]   bus_rdata;
    logic [3:0]    src_tick = '0;
    logic          dbg_halt = 1'b0;
    logic [CW-1:0] wd_count;
    logic          wd_timeout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdog_tick_ctrl #(.BASE_LOG2(BL), .LOW_LOG2(LL), .CNT_W(CW)) i_wdog_tick_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .wr_prot(wr_prot), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .dbg_halt(dbg_halt), .wd_count(wd_count),
        .wd_timeout(wd_timeout)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(logic a, int exp, string req);
        bus_addr = a;
        #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    task automatic pulse(int idx, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_tick[idx] = 1'b1;
            @(negedge clk); src_tick[idx] = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] cfgw(int src, int dv, bit dbg);
        return {7'b0, dbg, 2'b0, 2'(dv), 2'b0, 2'(src)};
    endfunction

    function automatic int ratio(int src, int dv);
        if (src == 1) return 1 << LL;
        if (src == 3) return 1;
        return 1 << (BL + 3 - dv);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk(1'b0, 16'h0000, "R1 cfg reset");
        rd_chk(1'b1, 16'h000A, "R1 ctl reset");
        chk("R1 count reset", int'(wd_count), 0);
        chk("R1 timeout reset", int'(wd_timeout), 0);
        // R9 reset key 0xA keeps the counter stopped
        pulse(0, 20);
        chk("R9 stopped by reset key", int'(wd_count), 0);
        // R2 layout
        wr(1'b0, 16'hFFFF);
        rd_chk(1'b0, 16'h0133, "R2 cfg layout");
        wr(1'b1, 16'hFFEF);
        rd_chk(1'b1, 16'h000F, "R2 ctl layout");
        wr(1'b1, 16'h0005);
        rd_chk(1'b1, 16'h0005, "R2 ctl key");
        // R4 R5 R6 full source/divider sweep
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                string tag;
                int r;
                tag = (s == 1) ? "R5" : (s == 3) ? "R6" : "R4";
                r = ratio(s, d);
                wr(1'b0, cfgw((s + 1) % 4, d, 1'b0));
                wr(1'b0, cfgw(s, d, 1'b0));
                wr(1'b1, 16'h0015);
                if (r > 1) begin
                    pulse(s, r - 1);
                    chk($sformatf("%s src=%0d div=%0d before period", tag, s, d), int'(wd_count), 0);
                end
                pulse(s, 1);
                chk($sformatf("%s src=%0d div=%0d one step", tag, s, d), int'(wd_count), 1);
            end
        end
        // R7 unselected sources ignored
        wr(1'b0, cfgw(1, 0, 1'b0));
        wr(1'b1, 16'h0015);
        pulse(0, 10); pulse(2, 10); pulse(3, 10);
        chk("R7 others ignored src1", int'(wd_count), 0);
        pulse(1, 8);
        chk("R7 selected src1 steps", int'(wd_count), 1);
        wr(1'b0, cfgw(3, 0, 1'b0));
        wr(1'b1, 16'h0015);
        pulse(0, 5); pulse(1, 5); pulse(2, 5);
        chk("R7 others ignored src3", int'(wd_count), 0);
        // R8 debug gate
        dbg_halt = 1'b1;
        pulse(3, 4);
        chk("R8 halted without debug-run", int'(wd_count), 0);
        wr(1'b0, cfgw(3, 0, 1'b1));
        pulse(3, 4);
        chk("R8 halted with debug-run", int'(wd_count), 4);
        dbg_halt = 1'b0;
        wr(1'b0, cfgw(3, 0, 1'b0));
        pulse(3, 2);
        chk("R8 no halt", int'(wd_count), 6);
        // R9 every key value
        for (int k = 0; k < 16; k++) begin
            wr(1'b1, 16'h0010 | 16'(k));
            pulse(3, 3);
            chk($sformatf("R9 key=%0d", k), int'(wd_count), (k == 10) ? 0 : 3);
        end
        // R10 clear strobe
        wr(1'b1, 16'h0005);
        chk("R10 bit4=0 keeps count", int'(wd_count), 3);
        wr(1'b1, 16'h0015);
        chk("R10 bit4=1 clears", int'(wd_count), 0);
        // R3 write protection
        pulse(3, 2);
        wr_prot = 1'b1;
        wr(1'b0, 16'h0133);
        rd_chk(1'b0, 16'h0003, "R3 cfg protected");
        wr(1'b1, 16'h001A);
        chk("R3 clear blocked", int'(wd_count), 2);
        rd_chk(1'b1, 16'h0005, "R3 key protected");
        pulse(3, 1);
        chk("R3 still running", int'(wd_count), 3);
        wr_prot = 1'b0;
        // R11 overflow
        wr(1'b1, 16'h0015);
        pulse(3, 15);
        chk("R11 at max", int'(wd_count), 15);
        chk("R11 no early timeout", int'(wd_timeout), 0);
        @(negedge clk); src_tick[3] = 1'b1;
        @(negedge clk); src_tick[3] = 1'b0;
        @(negedge clk);
        chk("R11 timeout pulse", int'(wd_timeout), 1);
        chk("R11 wrap to zero", int'(wd_count), 0);
        @(negedge clk);
        chk("R11 pulse one cycle", int'(wd_timeout), 0);
        // R12 restart on configuration change
        wr(1'b0, cfgw(0, 0, 1'b0));
        wr(1'b1, 16'h0015);
        pulse(0, 10);
        chk("R12 partial period", int'(wd_count), 0);
        wr(1'b0, cfgw(0, 1, 1'b0));
        pulse(0, 7);
        chk("R12 restarted, before period", int'(wd_count), 0);
        pulse(0, 1);
        chk("R12 full new period", int'(wd_count), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule